// File: doc/BRIEF.md
# Graphics SDRAM Command Decoder and Legality Checker

This block watches the control pins of a two-bank graphics SDRAM on every rising clock edge and turns them into one command code. Beyond the ordinary SDRAM commands, it uses the extra special-function pin to tell apart the graphics variants: the special mode load, the activate that arms per-bit write masking, and the block write. It is meant to sit on a memory bus as a protocol monitor or as the command front end of a memory model.

Alongside decoding, the block keeps its own view of the device: whether each bank is idle or open, whether a bank is still precharging, the programmed burst length and whether a data burst is running, with or without auto precharge. Every command is judged against that state. A command the device would not accept at that moment raises a one-cycle illegal pulse and leaves the tracked state untouched. The precharge delay is a parameter, `TRP_CYCLES`, counted in clock cycles.

Top module: `sgram_cmd_checker`

## Requirements
- R1: A synchronous active-high reset clears every output to zero (command code 0), closes both banks, clears any burst and precharge delay, and sets the burst length to one beat.
- R2: With `csN` high, or with `csN` low and `rasN`, `casN`, `weN` all high, the command is No Operation (code 0) and is never illegal. With `ckePrev` low, any pins decode as code 0.
- R3: With `csN`, `rasN`, `casN`, `weN` low, `dsf` low gives Mode Load (code 1) and `dsf` high gives Special Mode Load (code 2). Both are legal only when both banks are idle, no precharge delay runs and no burst is active. A legal Mode Load stores `modeField` as burst length: 0, 1, 2, 3 mean 1, 2, 4, 8 beats, 7 means full page; 4 to 6 make the Mode Load illegal.
- R4: `csN`, `rasN`, `casN` low, `weN` high, `dsf` low is Refresh (code 3) when `ckeCur` is high and Self Refresh Entry (code 4) when `ckeCur` is low; both follow the idle rule of R3. With `ckeCur` low, only codes 0, 4 and 15 can be produced.
- R5: `csN`, `rasN` low, `casN`, `weN` high is Activate (code 5) of bank `addr10`; `dsf` high arms write masking for that bank. It is legal only if that bank is closed and its precharge delay has run out; it then opens the bank (`bankOpen[b]`) and shows the mask state on `bankMasked[b]`.
- R6: `csN`, `casN` low, `rasN` high is Read (code 6, `weN` high, `dsf` low), Write (code 7, `weN` low, `dsf` low) or Block Write (code 8, `weN` low, `dsf` high), on bank `addr10`, with auto precharge requested by `addr9`. Each is legal only to an open bank and starts a burst: `burstBusy` is high for exactly the programmed number of cycles after the command edge.
- R7: While a burst with auto precharge runs, any Read, Write or Block Write is illegal. The bank closes on the edge the burst ends, and for a command sampled at edge E on a burst of L beats, the next Read or Write is legal from edge E+L+TRP_CYCLES+1 on.
- R8: `csN`, `rasN`, `weN` low, `casN` high, `dsf` low is Precharge (code 9); `addr9` high closes both banks (`cmdPreAll` high, `cmdBank` 0, `addr10` ignored), otherwise bank `addr10`. For a Precharge at edge P, an Activate of a closed bank is legal from edge P+TRP_CYCLES+1 on. A Precharge touching the bank of a running auto-precharge burst is illegal.
- R9: `csN`, `weN` low, `rasN`, `casN` high, `dsf` low is Burst Stop (code 10). It is legal only when the burst length is full page, and it ends a full-page burst, which otherwise runs indefinitely.
- R10: Any other pin pattern, and any non-idle command with `ckeCur` low, decodes as code 15 and is illegal; `cmdIllegal` stays high for that one cycle only.
- R11: An illegal command changes no bank, mask, burst or burst-length state.
- R12: All outputs change on the clock edge that samples the pins and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ckePrev | input | 1 | Clock enable seen on the previous edge |
| ckeCur | input | 1 | Clock enable seen on this edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function pin selecting graphics variants |
| addr10 | input | 1 | Bank select address bit |
| addr9 | input | 1 | Auto-precharge / precharge-all address bit |
| modeField | input | 3 | Burst length field loaded by Mode Load |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | 1 | Bank addressed by the command |
| cmdAutoPre | output | 1 | Auto precharge requested on a read or write |
| cmdPreAll | output | 1 | Precharge covers both banks |
| cmdIllegal | output | 1 | One-cycle pulse: command not allowed now |
| bankOpen | output | 2 | Per-bank open flag |
| bankMasked | output | 2 | Per-bank write masking armed (open banks only) |
| burstBusy | output | 1 | A data burst is in progress |

## Verification
The bench aims at the edges of the timing windows: a Read one cycle before and exactly on the first legal edge after an auto-precharge burst, and an Activate one cycle before and on the first legal edge after a Precharge; a counter off by one in either direction would accept the early command or reject the legal one. It drives commands with the wrong state (Mode Load with a bank open, Read to a closed bank, Burst Stop outside full-page mode, a reserved burst code) and checks that a design that let them through would show a changed bank map or a changed burst length. It also covers the pin patterns that only the special-function pin or a falling clock enable separates, where a decoder ignoring those pins would report the plain command instead of the graphics one or the invalid code.

// File: rtl/sgram_pkg.sv
package sgram_pkg;

  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_MODE      = 4'd1,
    CMD_SPECIAL   = 4'd2,
    CMD_REFRESH   = 4'd3,
    CMD_SELFREF   = 4'd4,
    CMD_ACTIVATE  = 4'd5,
    CMD_READ      = 4'd6,
    CMD_WRITE     = 4'd7,
    CMD_BLOCKWR   = 4'd8,
    CMD_PRECHARGE = 4'd9,
    CMD_BURSTSTOP = 4'd10,
    CMD_INVALID   = 4'd15
  } cmd_e;

  localparam int BL_FIELD_W = 3;
  localparam int BURST_W    = 4;
  localparam logic [BL_FIELD_W-1:0] BL_FULL_PAGE = 3'd7;

  typedef struct packed {
    cmd_e cmd;
    logic bank;
    logic autoPre;
    logic preAll;
    logic maskOn;
  } dec_t;

  typedef struct packed {
    logic                  loadMode;
    logic [BL_FIELD_W-1:0] modeCode;
    logic [1:0]            openBank;
    logic                  maskOn;
    logic [1:0]            closeBank;
    logic                  startBurst;
    logic                  burstAp;
    logic                  burstSel;
    logic                  stopBurst;
  } strobe_t;

  typedef struct packed {
    logic [1:0]            bankOpen;
    logic [1:0]            preBusy;
    logic                  burstBusy;
    logic                  burstAp;
    logic                  burstSel;
    logic                  apHold;
    logic [BL_FIELD_W-1:0] blCode;
  } status_t;

  function automatic logic blCodeValid(input logic [BL_FIELD_W-1:0] code);
    return (code <= 3'd3) || (code == BL_FULL_PAGE);
  endfunction

  function automatic logic [BURST_W-1:0] blBeats(input logic [BL_FIELD_W-1:0] code);
    return BURST_W'(1) << code[1:0];
  endfunction

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_pkg::*;
(
  input  logic ckePrev,
  input  logic ckeCur,
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic dsf,
  input  logic addr10,
  input  logic addr9,
  output dec_t dec
);

  dec_t raw;

  always_comb begin
    raw = '0;
    raw.cmd = CMD_NOP;
    if (ckePrev && !csN) begin
      unique case ({rasN, casN, weN})
        3'b111: raw.cmd = CMD_NOP;
        3'b000: raw.cmd = dsf ? CMD_SPECIAL : CMD_MODE;
        3'b001: raw.cmd = dsf ? CMD_INVALID : (ckeCur ? CMD_REFRESH : CMD_SELFREF);
        3'b011: begin
          raw.cmd    = CMD_ACTIVATE;
          raw.bank   = addr10;
          raw.maskOn = dsf;
        end
        3'b101: begin
          raw.cmd     = dsf ? CMD_INVALID : CMD_READ;
          raw.bank    = addr10;
          raw.autoPre = addr9;
        end
        3'b100: begin
          raw.cmd     = dsf ? CMD_BLOCKWR : CMD_WRITE;
          raw.bank    = addr10;
          raw.autoPre = addr9;
        end
        3'b010: begin
          raw.cmd    = dsf ? CMD_INVALID : CMD_PRECHARGE;
          raw.preAll = addr9;
          raw.bank   = addr9 ? 1'b0 : addr10;
        end
        default: raw.cmd = dsf ? CMD_INVALID : CMD_BURSTSTOP;
      endcase
    end
  end

  // A falling clock enable only accompanies idle or self-refresh entry.
  always_comb begin
    dec = raw;
    if (ckePrev && !ckeCur && !(raw.cmd inside {CMD_NOP, CMD_SELFREF}))
      dec.cmd = CMD_INVALID;
    if (dec.cmd == CMD_INVALID) begin
      dec.bank    = 1'b0;
      dec.autoPre = 1'b0;
      dec.preAll  = 1'b0;
      dec.maskOn  = 1'b0;
    end
  end

endmodule

// File: rtl/sgram_legal_ctrl.sv
module sgram_legal_ctrl
  import sgram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  dec_t                  dec,
  input  status_t               stat,
  input  logic [BL_FIELD_W-1:0] modeField,
  output strobe_t               strb,
  output logic                  illegal
);

  logic       allIdle;
  logic       tgtOpen;
  logic       tgtReady;
  logic       apBlock;
  logic [1:0] preMask;
  logic       preHitsAp;
  logic       fullPage;

  assign allIdle  = (stat.bankOpen == 2'b00) && (stat.preBusy == 2'b00) && !stat.burstBusy;
  assign tgtOpen  = stat.bankOpen[dec.bank];
  assign tgtReady = !stat.bankOpen[dec.bank] && !stat.preBusy[dec.bank];
  assign apBlock  = (stat.burstBusy && stat.burstAp) || stat.apHold;
  assign preMask  = dec.preAll ? 2'b11 : (dec.bank ? 2'b10 : 2'b01);
  assign preHitsAp = stat.burstBusy && stat.burstAp && preMask[stat.burstSel];
  assign fullPage = (stat.blCode == BL_FULL_PAGE);

  logic ok;

  always_comb begin
    unique case (dec.cmd)
      CMD_NOP:                   ok = 1'b1;
      CMD_MODE:                  ok = allIdle && blCodeValid(modeField);
      CMD_SPECIAL,
      CMD_REFRESH,
      CMD_SELFREF:               ok = allIdle;
      CMD_ACTIVATE:              ok = tgtReady;
      CMD_READ,
      CMD_WRITE,
      CMD_BLOCKWR:               ok = tgtOpen && !apBlock;
      CMD_PRECHARGE:             ok = !preHitsAp;
      CMD_BURSTSTOP:             ok = fullPage;
      default:                   ok = 1'b0;
    endcase
  end

  assign illegal = !ok;

  always_comb begin
    strb = '0;
    strb.modeCode = modeField;
    strb.maskOn   = dec.maskOn;
    strb.burstAp  = dec.autoPre;
    strb.burstSel = dec.bank;
    if (ok) begin
      unique case (dec.cmd)
        CMD_MODE:     strb.loadMode = 1'b1;
        CMD_ACTIVATE: strb.openBank[dec.bank] = 1'b1;
        CMD_READ,
        CMD_WRITE,
        CMD_BLOCKWR:  strb.startBurst = 1'b1;
        CMD_PRECHARGE: begin
          strb.closeBank = preMask & stat.bankOpen;
          strb.stopBurst = stat.burstBusy && preMask[stat.burstSel];
        end
        CMD_BURSTSTOP: strb.stopBurst = stat.burstBusy;
        default: ;
      endcase
    end
  end

  // R10: the invalid code is always judged illegal
  assert_invalid_flagged_R10: assert property (@(posedge clk) disable iff (rst)
    (dec.cmd == CMD_INVALID) |-> illegal);

  // R11: a rejected command issues no state-changing strobe
  assert_illegal_no_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!strb.loadMode && strb.openBank == 2'b00 && strb.closeBank == 2'b00
                 && !strb.startBurst && !strb.stopBurst));

  // R7: no burst may start while an auto-precharge burst or its hold-off runs
  assert_no_start_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((stat.burstBusy && stat.burstAp) || stat.apHold) |-> !strb.startBurst);

endmodule

// File: rtl/sgram_bank_path.sv
module sgram_bank_path
  import sgram_pkg::*;
#(
  parameter int TRP_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    strb,
  input  dec_t       dec,
  input  logic       illegal,
  output status_t    stat,
  output logic [3:0] cmdCode,
  output logic       cmdBank,
  output logic       cmdAutoPre,
  output logic       cmdPreAll,
  output logic       cmdIllegal,
  output logic [1:0] bankOpen,
  output logic [1:0] bankMasked,
  output logic       burstBusy
);

  localparam int TRP_W = (TRP_CYCLES < 2) ? 1 : $clog2(TRP_CYCLES + 1);
  localparam logic [TRP_W-1:0] TRP_LOAD = TRP_W'(TRP_CYCLES);

  logic [1:0]             openQ;
  logic [1:0]             maskQ;
  logic [1:0][TRP_W-1:0]  preCnt;
  logic [TRP_W-1:0]       apCnt;
  logic [BURST_W-1:0]     burstLeft;
  logic                   burstFullQ;
  logic                   burstApQ;
  logic                   burstSelQ;
  logic [BL_FIELD_W-1:0]  blCodeQ;
  logic                   busyNow;
  logic                   endNow;
  logic                   apClose;

  assign busyNow = burstFullQ || (burstLeft != '0);
  assign endNow  = busyNow && (strb.stopBurst || (!burstFullQ && burstLeft == BURST_W'(1)));
  assign apClose = endNow && burstApQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      openQ      <= '0;
      maskQ      <= '0;
      preCnt     <= '0;
      apCnt      <= '0;
      burstLeft  <= '0;
      burstFullQ <= 1'b0;
      burstApQ   <= 1'b0;
      burstSelQ  <= 1'b0;
      blCodeQ    <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (preCnt[b] != '0) preCnt[b] <= preCnt[b] - TRP_W'(1);
      end
      if (apCnt != '0) apCnt <= apCnt - TRP_W'(1);
      if (burstLeft != '0) burstLeft <= burstLeft - BURST_W'(1);

      if (endNow) begin
        burstFullQ <= 1'b0;
        burstLeft  <= '0;
        burstApQ   <= 1'b0;
      end
      if (apClose) begin
        openQ[burstSelQ]  <= 1'b0;
        preCnt[burstSelQ] <= TRP_LOAD;
        apCnt             <= TRP_LOAD;
      end
      for (int b = 0; b < 2; b++) begin
        if (strb.closeBank[b]) begin
          openQ[b]  <= 1'b0;
          preCnt[b] <= TRP_LOAD;
        end
        if (strb.openBank[b]) begin
          openQ[b] <= 1'b1;
          maskQ[b] <= strb.maskOn;
        end
      end
      if (strb.startBurst) begin
        burstApQ  <= strb.burstAp;
        burstSelQ <= strb.burstSel;
        if (blCodeQ == BL_FULL_PAGE) begin
          burstFullQ <= 1'b1;
          burstLeft  <= '0;
        end else begin
          burstFullQ <= 1'b0;
          burstLeft  <= blBeats(blCodeQ);
        end
      end
      if (strb.loadMode) blCodeQ <= strb.modeCode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdCode    <= CMD_NOP;
      cmdBank    <= 1'b0;
      cmdAutoPre <= 1'b0;
      cmdPreAll  <= 1'b0;
      cmdIllegal <= 1'b0;
    end else begin
      cmdCode    <= dec.cmd;
      cmdBank    <= dec.bank;
      cmdAutoPre <= dec.autoPre;
      cmdPreAll  <= dec.preAll;
      cmdIllegal <= illegal;
    end
  end

  always_comb begin
    stat.bankOpen  = openQ;
    stat.preBusy   = {preCnt[1] != '0, preCnt[0] != '0};
    stat.burstBusy = busyNow;
    stat.burstAp   = burstApQ;
    stat.burstSel  = burstSelQ;
    stat.apHold    = (apCnt != '0);
    stat.blCode    = blCodeQ;
  end

  assign bankOpen   = openQ;
  assign bankMasked = maskQ & openQ;
  assign burstBusy  = busyNow;

  // R5: an accepted activate leaves its bank open
  assert_bank0_opens_R5: assert property (@(posedge clk) disable iff (rst)
    strb.openBank[0] |=> openQ[0]);
  assert_bank1_opens_R5: assert property (@(posedge clk) disable iff (rst)
    strb.openBank[1] |=> openQ[1]);

  // R8: a precharged bank is closed and waiting out its delay
  assert_bank0_closes_R8: assert property (@(posedge clk) disable iff (rst)
    strb.closeBank[0] |=> (!openQ[0] && preCnt[0] != '0));
  assert_bank1_closes_R8: assert property (@(posedge clk) disable iff (rst)
    strb.closeBank[1] |=> (!openQ[1] && preCnt[1] != '0));

  // R9: a stop request ends the burst on that edge
  assert_stop_ends_burst_R9: assert property (@(posedge clk) disable iff (rst)
    strb.stopBurst |=> !busyNow);

  // R11: a rejected command leaves mask and burst length alone
  assert_illegal_keeps_state_R11: assert property (@(posedge clk) disable iff (rst)
    cmdIllegal |-> ($stable(maskQ) && $stable(blCodeQ)));

endmodule

// File: rtl/sgram_cmd_checker.sv
module sgram_cmd_checker
  import sgram_pkg::*;
#(
  parameter int TRP_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ckePrev,
  input  logic       ckeCur,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       dsf,
  input  logic       addr10,
  input  logic       addr9,
  input  logic [2:0] modeField,
  output logic [3:0] cmdCode,
  output logic       cmdBank,
  output logic       cmdAutoPre,
  output logic       cmdPreAll,
  output logic       cmdIllegal,
  output logic [1:0] bankOpen,
  output logic [1:0] bankMasked,
  output logic       burstBusy
);

  dec_t    dec;
  strobe_t strb;
  status_t stat;
  logic    illegal;

  sgram_cmd_decode u_decode (
    .ckePrev (ckePrev),
    .ckeCur  (ckeCur),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .dsf     (dsf),
    .addr10  (addr10),
    .addr9   (addr9),
    .dec     (dec)
  );

  sgram_legal_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .stat      (stat),
    .modeField (modeField),
    .strb      (strb),
    .illegal   (illegal)
  );

  sgram_bank_path #(.TRP_CYCLES(TRP_CYCLES)) u_path (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .dec        (dec),
    .illegal    (illegal),
    .stat       (stat),
    .cmdCode    (cmdCode),
    .cmdBank    (cmdBank),
    .cmdAutoPre (cmdAutoPre),
    .cmdPreAll  (cmdPreAll),
    .cmdIllegal (cmdIllegal),
    .bankOpen   (bankOpen),
    .bankMasked (bankMasked),
    .burstBusy  (burstBusy)
  );

endmodule

// File: tb/tb_sgram_cmd_checker.sv
`timescale 1ns/1ps
module tb_sgram_cmd_checker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ckePrev = 1'b1, ckeCur = 1'b1;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, dsf = 1'b0;
  logic       addr10 = 1'b0, addr9 = 1'b0;
  logic [2:0] modeField = 3'd0;
  logic [3:0] cmdCode;
  logic       cmdBank, cmdAutoPre, cmdPreAll, cmdIllegal;
  logic [1:0] bankOpen, bankMasked;
  logic       burstBusy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sgram_cmd_checker dut (
    .clk(clk), .rst(rst), .ckePrev(ckePrev), .ckeCur(ckeCur),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .dsf(dsf),
    .addr10(addr10), .addr9(addr9), .modeField(modeField),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre),
    .cmdPreAll(cmdPreAll), .cmdIllegal(cmdIllegal), .bankOpen(bankOpen),
    .bankMasked(bankMasked), .burstBusy(burstBusy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pinsIdle();
    ckePrev = 1'b1; ckeCur = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1;
    weN = 1'b1; dsf = 1'b0; addr10 = 1'b0; addr9 = 1'b0;
  endtask

  // One command per edge; outputs sampled 1 ns after that edge.
  task automatic send(input logic kp, input logic kc, input logic cs, input logic ras,
                      input logic cas, input logic we, input logic sf,
                      input logic a10, input logic a9, input logic [2:0] mf);
    @(negedge clk);
    ckePrev = kp; ckeCur = kc; csN = cs; rasN = ras; casN = cas; weN = we;
    dsf = sf; addr10 = a10; addr9 = a9; modeField = mf;
    @(posedge clk);
    #1;
    pinsIdle();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendMode(input logic sf, input logic [2:0] mf);
    send(1, 1, 0, 0, 0, 0, sf, 0, 0, mf);
  endtask
  task automatic sendAct(input logic b, input logic m);
    send(1, 1, 0, 0, 1, 1, m, b, 0, 3'd0);
  endtask
  task automatic sendRead(input logic b, input logic ap);
    send(1, 1, 0, 1, 0, 1, 0, b, ap, 3'd0);
  endtask
  task automatic sendWrite(input logic b, input logic ap, input logic blk);
    send(1, 1, 0, 1, 0, 0, blk, b, ap, 3'd0);
  endtask
  task automatic sendPre(input logic b, input logic all);
    send(1, 1, 0, 0, 1, 0, 0, b, all, 3'd0);
  endtask
  task automatic sendStop();
    send(1, 1, 0, 1, 1, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic testReset();
    check("R1 code after reset", cmdCode, 0);
    check("R1 illegal after reset", cmdIllegal, 0);
    check("R1 banks after reset", bankOpen, 0);
    check("R1 burst after reset", burstBusy, 0);
  endtask

  task automatic testNop();
    send(1, 1, 1, 0, 0, 0, 1, 1, 1, 3'd0);
    check("R2 deselect code", cmdCode, 0);
    check("R2 deselect legal", cmdIllegal, 0);
    send(1, 1, 0, 1, 1, 1, 1, 0, 0, 3'd0);
    check("R2 nop code", cmdCode, 0);
  endtask

  task automatic testMode();
    // R12: outputs do not move before the sampling edge
    @(negedge clk);
    csN = 0; rasN = 0; casN = 0; weN = 0; dsf = 0; modeField = 3'd1;
    #1;
    check("R12 code before edge", cmdCode, 0);
    @(posedge clk);
    #1;
    pinsIdle();
    check("R3 mode load code", cmdCode, 1);
    check("R3 mode load legal", cmdIllegal, 0);
    check("R12 code after edge", cmdCode, 1);
    sendMode(1, 3'd0);
    check("R3 special mode code", cmdCode, 2);
    check("R3 special mode legal", cmdIllegal, 0);
    sendMode(0, 3'd5);
    check("R3 reserved burst code illegal", cmdIllegal, 1);
    sendStop();
    check("R9 stop code", cmdCode, 10);
    check("R9 stop illegal outside full page", cmdIllegal, 1);
  endtask

  task automatic testRefresh();
    send(1, 1, 0, 0, 0, 1, 0, 0, 0, 3'd0);
    check("R4 refresh code", cmdCode, 3);
    check("R4 refresh legal", cmdIllegal, 0);
    send(1, 0, 0, 0, 0, 1, 0, 0, 0, 3'd0);
    check("R4 self refresh code", cmdCode, 4);
    check("R4 self refresh legal", cmdIllegal, 0);
    send(0, 1, 0, 0, 1, 1, 0, 1, 0, 3'd0);
    check("R2 low previous enable gives nop", cmdCode, 0);
    check("R2 no bank opened", bankOpen, 0);
  endtask

  task automatic testActivate();
    sendAct(1, 1);
    check("R5 activate code", cmdCode, 5);
    check("R5 activate bank", cmdBank, 1);
    check("R5 activate legal", cmdIllegal, 0);
    check("R5 bank1 open", bankOpen, 2);
    check("R5 bank1 masked", bankMasked, 2);
    sendAct(1, 0);
    check("R5 activate open bank illegal", cmdIllegal, 1);
    check("R11 mask unchanged", bankMasked, 2);
    sendMode(0, 3'd7);
    check("R3 mode load with open bank illegal", cmdIllegal, 1);
    send(1, 1, 0, 0, 0, 1, 0, 0, 0, 3'd0);
    check("R4 refresh with open bank illegal", cmdIllegal, 1);
  endtask

  task automatic testReadWrite();
    sendRead(1, 0);
    check("R6 read code", cmdCode, 6);
    check("R6 read bank", cmdBank, 1);
    check("R6 read no auto precharge", cmdAutoPre, 0);
    check("R6 burst beat 1", burstBusy, 1);
    idle(1);
    check("R6 burst beat 2", burstBusy, 1);
    idle(1);
    check("R11 burst length kept at 2 beats", burstBusy, 0);
    sendRead(0, 0);
    check("R6 read to closed bank illegal", cmdIllegal, 1);
    check("R11 no burst started", burstBusy, 0);
    sendWrite(1, 0, 1);
    check("R6 block write code", cmdCode, 8);
    check("R6 block write legal", cmdIllegal, 0);
    idle(2);
  endtask

  task automatic testAutoPrecharge();
    sendAct(0, 0);
    check("R5 bank0 unmasked", bankMasked, 2);
    sendWrite(0, 1, 0);                       // edge E, 2 beats, TRP 3
    check("R6 write code", cmdCode, 7);
    check("R6 write auto precharge", cmdAutoPre, 1);
    sendRead(1, 0);                           // E+1
    check("R7 read during auto precharge burst", cmdIllegal, 1);
    idle(3);                                  // E+2..E+4
    check("R7 bank0 closed at burst end", bankOpen, 2);
    sendRead(1, 0);                           // E+5
    check("R7 read one edge early", cmdIllegal, 1);
    sendRead(1, 0);                           // E+6
    check("R7 read on first legal edge", cmdIllegal, 0);
    sendAct(0, 0);                            // E+7
    check("R8 activate after delay legal", cmdIllegal, 0);
    check("R5 both banks open", bankOpen, 3);
  endtask

  task automatic testPrecharge();
    sendPre(1, 0);                            // P
    check("R8 precharge code", cmdCode, 9);
    check("R8 precharge bank", cmdBank, 1);
    check("R8 single precharge", cmdPreAll, 0);
    check("R8 bank1 closed", bankOpen, 1);
    sendAct(1, 0);                            // P+1
    check("R8 activate during delay", cmdIllegal, 1);
    idle(1);                                  // P+2
    sendAct(1, 0);                            // P+3
    check("R8 activate one edge early", cmdIllegal, 1);
    sendAct(1, 0);                            // P+4
    check("R8 activate on first legal edge", cmdIllegal, 0);
    sendPre(1, 1);
    check("R8 precharge all flag", cmdPreAll, 1);
    check("R8 precharge all ignores bank bit", cmdBank, 0);
    check("R8 both banks closed", bankOpen, 0);
    idle(3);
  endtask

  task automatic testFullPage();
    sendMode(0, 3'd7);
    check("R3 full page mode load legal", cmdIllegal, 0);
    sendStop();
    check("R9 stop legal in full page", cmdIllegal, 0);
    sendAct(0, 0);
    sendRead(0, 0);
    idle(5);
    check("R9 full page burst keeps running", burstBusy, 1);
    sendStop();
    check("R9 stop ends burst", burstBusy, 0);
  endtask

  task automatic testInvalid();
    send(1, 1, 0, 0, 0, 1, 1, 0, 0, 3'd0);
    check("R10 invalid code", cmdCode, 15);
    check("R10 invalid flagged", cmdIllegal, 1);
    check("R11 banks unchanged", bankOpen, 1);
    idle(1);
    check("R10 flag lasts one cycle", cmdIllegal, 0);
    send(1, 0, 0, 1, 0, 1, 0, 0, 0, 3'd0);
    check("R4 read with falling enable invalid", cmdCode, 15);
    check("R10 falling enable flagged", cmdIllegal, 1);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pinsIdle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    testReset();
    testNop();
    testMode();
    testRefresh();
    testActivate();
    testReadWrite();
    testAutoPrecharge();
    testPrecharge();
    testFullPage();
    testInvalid();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule